// File: doc/BRIEF.md
# Decoupled dq Current Regulator

This block closes the current loop for one pair of rotating-frame axes (direct and quadrature) in fixed point. Each time the sample strobe is raised, every axis runs a one-pole low-pass filter over its measured current and subtracts the filtered value from its reference. The difference drives a velocity-form PI law. A decoupling term is then folded in: it comes from the opposite axis's measured current, smoothed by a much slower one-pole filter and scaled by a fixed gain. The resulting voltage command is registered and flagged valid for one cycle.

Full scale for both current and voltage is the code 0x3FFF. Every coefficient is an integer ratio to that scale: the product is shifted right by 14 with rounding. The update period is meant to be about 19.5 µs, so the strobe is sparse compared with the clock. A downstream voltage limiter can report saturation on each axis. While it does, that axis's PI state is frozen so that the integral does not wind up. A third, zero-sequence channel can be built from the same axis datapath.

Top module: `dq_current_reg`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `vout_vld` is 0 and both voltage outputs are 0. All filter, PI and previous-error state restarts from 0, and `vout_vld` stays 0 until a strobe has been processed.
- R2: `vout_vld` is 1 in exactly the cycle after a clock edge that samples `smp_vld` high, and 0 otherwise.
- R3: The feedback filter state f is updated per strobe as f = sat(f + q(meas − f, 0x0C98)). Here q(a,k) = (a·k + 0x2000) >>> 14, an arithmetic shift that rounds halves upward.
- R4: The error is e = sat(ref − f), using the updated f. The PI state u is updated as u = sat(u + q(e − e_prev, 0x22C4) + q(e, 0x0011)), after which e_prev = e.
- R5: The cross filter state x is updated per strobe as x = sat(x + q(m_other − x, 0x0028)), where m_other is the raw measurement of the opposite axis. The decoupling term is c = q(x, 0x0666).
- R6: The d output is sat(u_d − c_d), built from the q current. The q output is sat(u_q + c_q), built from the d current.
- R7: sat() clamps to the range −0x3FFF..+0x3FFF and never wraps. This applies to every filter state, error, PI state and output.
- R8: When an axis's `sat_*` input is 1 at a strobe, that axis keeps its PI state and previous error unchanged, and its output uses the held PI state. Both filters still update.
- R9: With `smp_vld` low, all inputs are ignored. The outputs keep their last value, and the next strobe's result is unaffected by input activity in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one cycle per control period |
| ref_d | input | 16 | Signed d-axis current reference |
| ref_q | input | 16 | Signed q-axis current reference |
| meas_d | input | 16 | Signed d-axis measured current |
| meas_q | input | 16 | Signed q-axis measured current |
| sat_d | input | 1 | Limiter reports d-axis saturation |
| sat_q | input | 1 | Limiter reports q-axis saturation |
| vout_d | output | 16 | Signed d-axis voltage command |
| vout_q | output | 16 | Signed q-axis voltage command |
| vout_vld | output | 1 | Outputs updated, one-cycle pulse |

## Verification
Every state register feeds the output of the same strobe. A wrong coefficient, a wrong rounding step or a wrong sign therefore shows up at `vout_d`/`vout_q` in the cycle right after the first strobe that exercises it. Faults in the slow cross filter and in the integrator grow over repeated strobes, so long random runs are compared against a bit-exact model. Frozen or leaking PI state under limiter saturation becomes visible at the first strobe after `sat_*` drops.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
  localparam int DQ_W    = 16;
  localparam int DQ_AW   = DQ_W + 4;
  localparam int DQ_FRAC = 14;
  localparam int DQ_LIM  = 16'h3FFF;
  localparam int DQ_PW   = DQ_AW + DQ_W;

  typedef logic signed [DQ_W-1:0]  samp_t;
  typedef logic signed [DQ_AW-1:0] acc_t;
  typedef logic signed [DQ_PW-1:0] prod_t;

  localparam acc_t  LIM_A  = acc_t'(DQ_LIM);
  localparam prod_t HALF_P = prod_t'(2 ** (DQ_FRAC - 1));

  localparam samp_t K_FB_DEF = samp_t'(16'h0C98);
  localparam samp_t K_FF_DEF = samp_t'(16'h0028);
  localparam samp_t K_C_DEF  = samp_t'(16'h22C4);
  localparam samp_t K_I_DEF  = samp_t'(16'h0011);
  localparam samp_t K_G_DEF  = samp_t'(16'h0666);

  function automatic acc_t widen(input samp_t s);
    return acc_t'(s);
  endfunction

  function automatic acc_t mulq(input acc_t a, input samp_t k);
    prod_t p;
    p = prod_t'(a) * prod_t'(k);
    p = p + HALF_P;
    p = p >>> DQ_FRAC;
    return acc_t'(p);
  endfunction

  function automatic samp_t satq(input acc_t v);
    if (v > LIM_A)
      return samp_t'(LIM_A);
    else if (v < -LIM_A)
      return samp_t'(-LIM_A);
    else
      return samp_t'(v);
  endfunction
endpackage

// File: rtl/dqc_lpf.sv
module dqc_lpf
  import dqc_pkg::*;
#(
  parameter samp_t K = K_FB_DEF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  samp_t x,
  output samp_t y_nxt
);
  samp_t y_q;

  always_comb y_nxt = satq(widen(y_q) + mulq(widen(x) - widen(y_q), K));

  always_ff @(posedge clk) begin
    if (rst)     y_q <= '0;
    else if (en) y_q <= y_nxt;
  end

  // R9
  lpf_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y_q));
endmodule

// File: rtl/dqc_pi.sv
module dqc_pi
  import dqc_pkg::*;
#(
  parameter samp_t KC = K_C_DEF,
  parameter samp_t KI = K_I_DEF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  hold,
  input  samp_t err,
  output samp_t u_cur
);
  samp_t u_q, e_q, u_calc;

  always_comb begin
    u_calc = satq(widen(u_q) + mulq(widen(err) - widen(e_q), KC) + mulq(widen(err), KI));
    u_cur  = hold ? u_q : u_calc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_q <= '0;
      e_q <= '0;
    end else if (en && !hold) begin
      u_q <= u_calc;
      e_q <= err;
    end
  end

  // R8
  windup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && hold) |=> ($stable(u_q) && $stable(e_q)));
endmodule

// File: rtl/dqc_axis.sv
module dqc_axis
  import dqc_pkg::*;
#(
  parameter bit    NEG_FF = 1'b0,
  parameter samp_t KFB    = K_FB_DEF,
  parameter samp_t KFF    = K_FF_DEF,
  parameter samp_t KC     = K_C_DEF,
  parameter samp_t KI     = K_I_DEF,
  parameter samp_t KG     = K_G_DEF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  sat,
  input  samp_t ref_i,
  input  samp_t meas,
  input  samp_t xmeas,
  output samp_t v
);
  samp_t fb_nxt, xf_nxt, err, u;
  acc_t  ffterm;
  samp_t v_nxt;

  dqc_lpf #(.K(KFB)) u_fb (
    .clk(clk), .rst(rst), .en(en), .x(meas), .y_nxt(fb_nxt)
  );

  dqc_lpf #(.K(KFF)) u_xf (
    .clk(clk), .rst(rst), .en(en), .x(xmeas), .y_nxt(xf_nxt)
  );

  always_comb err = satq(widen(ref_i) - widen(fb_nxt));

  dqc_pi #(.KC(KC), .KI(KI)) u_pi (
    .clk(clk), .rst(rst), .en(en), .hold(sat), .err(err), .u_cur(u)
  );

  always_comb ffterm = mulq(widen(xf_nxt), KG);

  generate
    if (NEG_FF) begin : g_sub
      always_comb v_nxt = satq(widen(u) - ffterm);
    end else begin : g_add
      always_comb v_nxt = satq(widen(u) + ffterm);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     v <= '0;
    else if (en) v <= v_nxt;
  end

  // R7
  vout_range_chk: assert property (@(posedge clk) disable iff (rst)
    (widen(v) <= LIM_A) && (widen(v) >= -LIM_A));
endmodule

// File: rtl/dq_current_reg.sv
module dq_current_reg
  import dqc_pkg::*;
#(
  parameter samp_t KFB = K_FB_DEF,
  parameter samp_t KFF = K_FF_DEF,
  parameter samp_t KC  = K_C_DEF,
  parameter samp_t KI  = K_I_DEF,
  parameter samp_t KG  = K_G_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_vld,
  input  logic signed [15:0] ref_d,
  input  logic signed [15:0] ref_q,
  input  logic signed [15:0] meas_d,
  input  logic signed [15:0] meas_q,
  input  logic               sat_d,
  input  logic               sat_q,
  output logic signed [15:0] vout_d,
  output logic signed [15:0] vout_q,
  output logic               vout_vld
);
  localparam int NAX = 2;

  samp_t ref_a  [NAX];
  samp_t meas_a [NAX];
  samp_t vout_a [NAX];
  logic  sat_a  [NAX];

  assign ref_a[0]  = ref_d;
  assign ref_a[1]  = ref_q;
  assign meas_a[0] = meas_d;
  assign meas_a[1] = meas_q;
  assign sat_a[0]  = sat_d;
  assign sat_a[1]  = sat_q;

  generate
    for (genvar g = 0; g < NAX; g++) begin : g_ax
      dqc_axis #(
        .NEG_FF(g == 0), .KFB(KFB), .KFF(KFF), .KC(KC), .KI(KI), .KG(KG)
      ) u_axis (
        .clk(clk), .rst(rst), .en(smp_vld), .sat(sat_a[g]),
        .ref_i(ref_a[g]), .meas(meas_a[g]), .xmeas(meas_a[NAX-1-g]),
        .v(vout_a[g])
      );
    end
  endgenerate

  assign vout_d = vout_a[0];
  assign vout_q = vout_a[1];

  always_ff @(posedge clk) begin
    if (rst) vout_vld <= 1'b0;
    else     vout_vld <= smp_vld;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!vout_vld && vout_d == '0 && vout_q == '0));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> vout_vld);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !vout_vld);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(vout_d) && $stable(vout_q)));
endmodule

// File: tb/dq_current_reg_test.sv
`timescale 1ns/1ps
module dq_current_reg_test;
  logic clk = 1'b0;
  logic rst;
  logic smp_vld;
  logic signed [15:0] ref_d, ref_q, meas_d, meas_q;
  logic sat_d, sat_q;
  logic signed [15:0] vout_d, vout_q;
  logic vout_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  longint f_m [2];
  longint x_m [2];
  longint u_m [2];
  longint e_m [2];
  longint exp_d, exp_q;

  always #2.5 clk = ~clk;

  dq_current_reg uut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .ref_d(ref_d), .ref_q(ref_q), .meas_d(meas_d), .meas_q(meas_q),
    .sat_d(sat_d), .sat_q(sat_q),
    .vout_d(vout_d), .vout_q(vout_q), .vout_vld(vout_vld)
  );

  function automatic longint sat_f(input longint v);
    if (v > 16383) return 16383;
    if (v < -16383) return -16383;
    return v;
  endfunction

  function automatic longint q_f(input longint a, input longint k);
    return (a * k + 8192) >>> 14;
  endfunction

  task automatic chk(input string tag, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 2; a++) begin
      f_m[a] = 0; x_m[a] = 0; u_m[a] = 0; e_m[a] = 0;
    end
    exp_d = 0; exp_q = 0;
  endtask

  task automatic model_step(input longint rd, input longint rq, input longint md,
                            input longint mq, input bit sd, input bit sq);
    longint r [2];
    longint m [2];
    bit     s [2];
    longint e, uc, c;
    longint v [2];
    r[0] = rd; r[1] = rq; m[0] = md; m[1] = mq; s[0] = sd; s[1] = sq;
    for (int a = 0; a < 2; a++) begin
      f_m[a] = sat_f(f_m[a] + q_f(m[a] - f_m[a], 'h0C98));
      x_m[a] = sat_f(x_m[a] + q_f(m[1-a] - x_m[a], 'h0028));
      e = sat_f(r[a] - f_m[a]);
      uc = sat_f(u_m[a] + q_f(e - e_m[a], 'h22C4) + q_f(e, 'h0011));
      if (!s[a]) begin
        u_m[a] = uc;
        e_m[a] = e;
      end
      c = q_f(x_m[a], 'h0666);
      v[a] = (a == 0) ? sat_f(u_m[a] - c) : sat_f(u_m[a] + c);
    end
    exp_d = v[0]; exp_q = v[1];
  endtask

  // Apply one strobe at a falling edge, check the result at the next falling edge.
  task automatic strobe(input int rd, input int rq, input int md, input int mq,
                        input bit sd, input bit sq, input string tag_d, input string tag_q);
    ref_d = 16'(rd); ref_q = 16'(rq); meas_d = 16'(md); meas_q = 16'(mq);
    sat_d = sd; sat_q = sq; smp_vld = 1'b1;
    model_step(longint'(rd), longint'(rq), longint'(md), longint'(mq), sd, sq);
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R2 valid after strobe", longint'(vout_vld), 1);
    chk(tag_d, longint'(vout_d), exp_d);
    chk(tag_q, longint'(vout_q), exp_q);
  endtask

  // Idle cycles with scrambled inputs: nothing may change.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      ref_d = 16'($urandom); ref_q = 16'($urandom);
      meas_d = 16'($urandom); meas_q = 16'($urandom);
      sat_d = 1'($urandom); sat_q = 1'($urandom);
      @(negedge clk);
      chk("R2 valid low when idle", longint'(vout_vld), 0);
      chk("R9 d output held", longint'(vout_d), exp_d);
      chk("R9 q output held", longint'(vout_q), exp_q);
    end
  endtask

  function automatic int rnd_val(input int span);
    return int'($urandom_range(2 * span)) - span;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; smp_vld = 1'b0;
    ref_d = '0; ref_q = '0; meas_d = '0; meas_q = '0; sat_d = 1'b0; sat_q = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", longint'(vout_vld), 0);
    chk("R1 d zero in reset", longint'(vout_d), 0);
    chk("R1 q zero in reset", longint'(vout_q), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid low before first strobe", longint'(vout_vld), 0);
    idle(2);

    // Feedback filter and cross term from d current only
    for (int i = 0; i < 6; i++) begin
      strobe(0, 0, 10000, 0, 1'b0, 1'b0, "R3 d-axis filtered feedback", "R5 q-axis cross term from d");
    end
    idle(1);
    // Cross term from q current only: d must subtract
    for (int i = 0; i < 6; i++) begin
      strobe(0, 0, 0, -9000, 1'b0, 1'b0, "R6 d-axis subtracts cross term", "R4 q-axis PI");
    end
    // Reference step, PI response
    for (int i = 0; i < 8; i++) begin
      strobe(6000, -4000, 0, 0, 1'b0, 1'b0, "R4 d-axis PI step", "R4 q-axis PI step");
    end
    // Anti-windup: d saturated, q free, then release
    for (int i = 0; i < 4; i++) begin
      strobe(12000, 12000, 0, 0, 1'b1, 1'b0, "R8 d-axis PI held", "R8 q-axis PI runs");
    end
    idle(2);
    strobe(12000, 12000, 0, 0, 1'b0, 1'b1, "R8 d-axis after release", "R8 q-axis PI held");
    // Extreme inputs: clamp
    for (int i = 0; i < 10; i++) begin
      strobe(32767, -32768, -32768, 32767, 1'b0, 1'b0, "R7 d-axis clamp", "R7 q-axis clamp");
    end
    for (int i = 0; i < 10; i++) begin
      strobe(-32768, 32767, 32767, -32768, 1'b0, 1'b0, "R7 d-axis clamp reverse", "R7 q-axis clamp reverse");
    end
    // Constrained random
    for (int i = 0; i < 400; i++) begin
      strobe(rnd_val(20000), rnd_val(20000), rnd_val(20000), rnd_val(20000),
             ($urandom_range(7) == 0), ($urandom_range(7) == 0),
             "R4 R6 random d", "R4 R6 random q");
      idle(int'($urandom_range(3)));
    end
    // Reset mid-run clears all state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 valid low after reset", longint'(vout_vld), 0);
    chk("R1 d zero after reset", longint'(vout_d), 0);
    strobe(3000, 3000, 1000, 2000, 1'b0, 1'b0, "R1 d restart from zero state", "R1 q restart from zero state");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule